// File: doc/BRIEF.md
# Reference-Gated Clock Frequency Counter

This block measures how fast an unknown test clock runs. A register-side clock, which also serves as the divided crystal reference, counts down a window whose length software chooses in reference ticks. While the window is open, a counter clocked by the test clock itself counts that clock's cycles. When the window closes, the result crosses back to the register side, a done flag rises, and software reads the count. It then converts the count to hertz using the window length.

The test-side counter is cleared only by logic that the test clock drives. A stopped test clock therefore leaves the previous result in place. Software detects a dead clock by running a short window and then a long one: equal results mean that the clock never toggled. A separate gate bit enables the divided reference branch. While the gate is off, the window does not advance.

Register map:

| Address | Access | Content |
|---------|--------|---------|
| 0 | read/write | control word |
| 1 | read only | status word |
| 2 | read/write | gate register |
| 3 | read only | reads as zero |

Top module: `freq_meter`

## Requirements
- R1: A write to address 0 with bit 20 clear stops the run. It loads the window length from bits WIN_W-1:0 and leaves done at 0. Address 0 reads back the last word written.
- R2: The status word at address 1 holds done at bit 25 and the count in its low CNT_W bits, with CNT_W at most 25. All other bits read as 0. After reset the status word, the control word and the gate register all read 0.
- R3: A write to address 0 with bit 20 set starts a run. Done rises no earlier than the programmed number of gated reference cycles. The count then lies within 3 of ticks × f_test / f_ref.
- R4: Once done is set, done stays at 1 and the count stays frozen for as long as address 0 is not written.
- R5: Any write to address 0 clears done on the next cycle.
- R6: If the test clock does not toggle during a run, done still rises and the count keeps the value of the previous run.
- R7: The test-side counter saturates at all ones in CNT_W bits instead of wrapping.
- R8: Bit 0 of the gate register at address 2 enables the reference branch. While that bit is 0, the window does not advance and done does not rise.
- R9: Window lengths up to 0x10000 reference ticks are accepted with the default WIN_W of 17.
- R10: Each run starts counting from zero. A run begins only after the test side reports that the previous run has stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock, which also serves as the divided reference |
| rst_n | input | 1 | Asynchronous reset, active low |
| tst_clk | input | 1 | Clock under measurement |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 2 | Register address (0 control, 1 status, 2 gate) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for addr |

## Verification
The assertions assume that the test clock never stops while a run holds its enable high. If it did, the returned stopped indication would never arrive and the run could not finish. The stimulus therefore halts the test clock only between runs, after done is seen.

The assertions also assume that the test clock is fast enough to answer the start request within the drain settle interval. All test periods in the bench stay within a few reference periods.

// File: rtl/freq_meter_pkg.sv
package freq_meter_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_RUN,
    ST_DRAIN,
    ST_DONE
  } meas_state_t;

  localparam int CTRL_EN_BIT  = 20;
  localparam int DONE_BIT     = 25;
  localparam int STAT_CNT_MAX = 25;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_GATE = 2'd2;

  // Saturating increment, held at top.
  function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] top);
    return (v >= top) ? top : v + 32'd1;
  endfunction

  // True when the remaining window count closes on this gated tick.
  function automatic logic window_last(input logic [31:0] remaining);
    return remaining <= 32'd1;
  endfunction

endpackage

// File: rtl/fm_sync.sv
module fm_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/fm_tst_counter.sv
module fm_tst_counter
  import freq_meter_pkg::*;
#(
  parameter int CNT_W = 25
) (
  input  logic             tst_clk,
  input  logic             rst_n,
  input  logic             run_req,
  output logic             busy,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic en_s;
  logic en_d;
  logic start_evt;

  fm_sync #(.W(1)) u_en_sync (
    .clk  (tst_clk),
    .rst_n(rst_n),
    .d    (run_req),
    .q    (en_s)
  );

  always_ff @(posedge tst_clk or negedge rst_n) begin
    if (!rst_n) en_d <= 1'b0;
    else        en_d <= en_s;
  end

  assign start_evt = en_s & ~en_d;
  assign busy      = en_s;

  always_ff @(posedge tst_clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (start_evt) cnt <= '0;
    else if (en_s)      cnt <= CNT_W'(sat_inc(32'(cnt), 32'(CNT_MAX)));
  end

  AST_SAT_STICKS: assert property (@(posedge tst_clk) disable iff (!rst_n)
    (en_s && !start_evt && cnt == CNT_MAX) |=> cnt == CNT_MAX); // R7
  AST_IDLE_FROZEN: assert property (@(posedge tst_clk) disable iff (!rst_n)
    !en_s |=> $stable(cnt)); // R6
  AST_START_CLEARS: assert property (@(posedge tst_clk) disable iff (!rst_n)
    start_evt |=> cnt == '0); // R10
endmodule

// File: rtl/fm_window.sv
module fm_window
  import freq_meter_pkg::*;
#(
  parameter int WIN_W  = 17,
  parameter int CNT_W  = 25,
  parameter int SETTLE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic             start,
  input  logic [WIN_W-1:0] ticks,
  input  logic             gate_en,
  input  logic             ack,
  input  logic [CNT_W-1:0] tst_cnt,
  output logic             run_req,
  output logic             done,
  output logic [CNT_W-1:0] result
);
  localparam int SET_W = $clog2(SETTLE + 1);
  localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE - 1);

  meas_state_t      state;
  logic [WIN_W-1:0] win;
  logic [SET_W-1:0] settle;
  logic             win_expire;
  logic             drain_ok;

  assign win_expire = (state == ST_RUN) && gate_en && window_last(32'(win));
  assign drain_ok   = (state == ST_DRAIN) && !ack && (settle == SET_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      win    <= '0;
      settle <= '0;
      result <= '0;
    end else if (ctrl_wr) begin
      win    <= ticks;
      settle <= '0;
      state  <= start ? ST_ARM : ST_IDLE;
    end else begin
      case (state)
        ST_ARM: if (!ack) state <= ST_RUN;
        ST_RUN: begin
          if (win_expire) begin
            win   <= '0;
            state <= ST_DRAIN;
          end else if (gate_en) begin
            win <= win - WIN_W'(1);
          end
        end
        ST_DRAIN: begin
          if (ack)           settle <= '0;
          else if (drain_ok) begin
            result <= tst_cnt;
            state  <= ST_DONE;
          end else           settle <= settle + SET_W'(1);
        end
        default: ;
      endcase
    end
  end

  assign run_req = (state == ST_RUN);
  assign done    = (state == ST_DONE);

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ctrl_wr) |=> done); // R4
  AST_RESULT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ctrl_wr) |=> $stable(result)); // R4
  AST_WR_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !done); // R5
  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && !gate_en && !ctrl_wr) |=> ($stable(win) && state == ST_RUN)); // R8
  AST_RUN_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_req) |-> !$past(ack)); // R10
endmodule

// File: rtl/freq_meter.sv
module freq_meter
  import freq_meter_pkg::*;
#(
  parameter int WIN_W  = 17,
  parameter int CNT_W  = 25,
  parameter int SETTLE = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tst_clk,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);
  logic [31:0]      ctrl_q;
  logic             gate_q;
  logic             ctrl_wr;
  logic             run_req;
  logic             busy;
  logic             ack;
  logic             done;
  logic [CNT_W-1:0] tst_cnt;
  logic [CNT_W-1:0] result;
  logic [31:0]      status;

  assign ctrl_wr = wr_en && (addr == ADDR_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      gate_q <= 1'b0;
    end else if (wr_en) begin
      if (addr == ADDR_CTRL) ctrl_q <= wdata;
      if (addr == ADDR_GATE) gate_q <= wdata[0];
    end
  end

  fm_window #(.WIN_W(WIN_W), .CNT_W(CNT_W), .SETTLE(SETTLE)) u_window (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctrl_wr(ctrl_wr),
    .start  (wdata[CTRL_EN_BIT]),
    .ticks  (wdata[WIN_W-1:0]),
    .gate_en(gate_q),
    .ack    (ack),
    .tst_cnt(tst_cnt),
    .run_req(run_req),
    .done   (done),
    .result (result)
  );

  fm_tst_counter #(.CNT_W(CNT_W)) u_tst (
    .tst_clk(tst_clk),
    .rst_n  (rst_n),
    .run_req(run_req),
    .busy   (busy),
    .cnt    (tst_cnt)
  );

  fm_sync #(.W(1)) u_ack_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (busy),
    .q    (ack)
  );

  always_comb begin
    status                = '0;
    status[DONE_BIT]      = done;
    status[CNT_W-1:0]     = result;
  end

  always_comb begin
    case (addr)
      ADDR_CTRL: rdata = ctrl_q;
      ADDR_STAT: rdata = status;
      ADDR_GATE: rdata = {31'd0, gate_q};
      default:   rdata = '0;
    endcase
  end

  AST_STAT_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    status[31:DONE_BIT+1] == '0); // R2
endmodule

// File: tb/tb_freq_meter.sv
`timescale 1ns/1ps
module tb_freq_meter;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 13;
  localparam int CNT_MAX    = (1 << CNT_W) - 1;

  logic        clk = 1'b0;
  logic        tst_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  bit  tst_run = 1'b1;
  real tst_half = 5.0;
  int  n_tests = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;

  freq_meter #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .tst_clk(tst_clk),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always begin
    if (tst_run) #(tst_half) tst_clk = ~tst_clk;
    else #1;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  // Starts a run and polls for done; returns status and polled cycles.
  task automatic measure(input int ticks, input int max_wait,
                         output logic [31:0] st, output int waited);
    wr(2'd0, 32'd0);
    wr(2'd0, (32'd1 << 20) | 32'(ticks));
    waited = 0;
    rd(2'd1, st);
    while (!st[25] && waited < max_wait) begin
      waited++;
      rd(2'd1, st);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] st, st2, v;
    int waited;
    int ticks_set[4];
    real per_set[4];
    int last_cnt;
    ticks_set = '{16, 100, 1000, 4096};
    per_set   = '{7.0, 10.0, 23.0, 40.0};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(2'd1, v); check(v == 32'd0, "R2 reset status", v, 0);
    rd(2'd0, v); check(v == 32'd0, "R2 reset control", v, 0);
    rd(2'd2, v); check(v == 32'd0, "R2 reset gate", v, 0);

    wr(2'd2, 32'd1);

    foreach (per_set[p]) begin
      foreach (ticks_set[t]) begin
        int exp_c;
        int c;
        tst_half = per_set[p] / 2.0;
        exp_c = int'((real'(ticks_set[t]) * CLK_PERIOD) / per_set[p]);
        measure(ticks_set[t], ticks_set[t] + 200, st, waited);
        c = int'(st[CNT_W-1:0]);
        check(st[25] == 1'b1, "R3 done rises", st[25], 1);
        check(waited >= ticks_set[t], "R3 window length", waited, ticks_set[t]);
        check(c >= exp_c - 3 && c <= exp_c + 3, "R3 count", c, exp_c);
        check(st[24:CNT_W] == '0 && st[31:26] == '0, "R2 reserved bits", st, st & 32'h0200_1fff);
        last_cnt = c;
      end
    end

    rd(2'd0, v);
    check(v == ((32'd1 << 20) | 32'd4096), "R1 control readback", v, (32'd1 << 20) | 32'd4096);

    repeat (200) @(negedge clk);
    rd(2'd1, st2);
    check(st2 == st, "R4 done and count held", st2, st);

    wr(2'd0, 32'd50);
    rd(2'd1, v);
    check(v[25] == 1'b0, "R1 stop write clears done", v[25], 0);
    check(v[25] == 1'b0, "R5 write clears done", v[25], 0);
    repeat (100) @(negedge clk);
    rd(2'd1, v);
    check(v[25] == 1'b0, "R1 stopped, no done", v[25], 0);

    tst_run = 1'b0;
    repeat (10) @(negedge clk);
    measure(4096, 4300, st, waited);
    check(st[25] == 1'b1, "R6 done with dead clock", st[25], 1);
    check(int'(st[CNT_W-1:0]) == last_cnt, "R6 stale count long", st[CNT_W-1:0], last_cnt);
    measure(256, 500, st2, waited);
    check(st2[CNT_W-1:0] == st[CNT_W-1:0], "R6 short equals long", st2[CNT_W-1:0], st[CNT_W-1:0]);

    tst_half = 5.0;
    tst_run = 1'b1;
    measure(4096, 4300, st, waited);
    check(int'(st[CNT_W-1:0]) >= 4093 && int'(st[CNT_W-1:0]) <= 4099, "R10 fresh count", st[CNT_W-1:0], 4096);

    wr(2'd2, 32'd0);
    wr(2'd0, 32'd0);
    wr(2'd0, (32'd1 << 20) | 32'd100);
    repeat (300) @(negedge clk);
    rd(2'd1, v);
    check(v[25] == 1'b0, "R8 gate off holds window", v[25], 0);
    wr(2'd2, 32'd1);
    repeat (50) @(negedge clk);
    rd(2'd1, v);
    check(v[25] == 1'b0, "R8 window resumes from start", v[25], 0);
    repeat (150) @(negedge clk);
    rd(2'd1, v);
    check(v[25] == 1'b1, "R8 done after gate on", v[25], 1);

    tst_half = 3.5;
    measure(32'h10000, 32'h10000 + 300, st, waited);
    check(st[25] == 1'b1, "R9 long window done", st[25], 1);
    check(waited >= 32'h10000, "R9 long window length", waited, 32'h10000);
    check(int'(st[CNT_W-1:0]) == CNT_MAX, "R7 saturation", st[CNT_W-1:0], CNT_MAX);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule